// File: doc/BRIEF.md
# Streaming SHA-2 Message Padder

This block sits in front of a SHA-2 message scheduler and turns a raw message, fed one word per clock, into the padded word stream the scheduler consumes during the first sixteen rounds of each block. It pads on the fly as words arrive and holds no block-sized buffer, so there is no sixteen-cycle fill latency per block. A parameter selects a 32-bit word (512-bit blocks) or a 64-bit word (1024-bit blocks).

The consumer raises `word_req_i` on each cycle in which it wants a padded word; with the request low the padder holds its state. A message starts with `msg_start_i` together with its first word and ends with `msg_last_i` on its last word, where `bits_valid_i` gives the number of real message bits in that word, counted from the MSB. The padder masks the unused bits, inserts the single one bit, fills with zero words and closes the final block with the message length in bits as two words, high word first. Each padded word appears on `pad_word_o` with `pad_valid_o` one clock after the requesting cycle; `pad_done_o` marks the final length word.

Top module: `sha2pad_stream`

## Requirements
- R1: While reset is asserted and right after it, `pad_valid_o`, `pad_done_o` and `pad_word_o` are all zero.
- R2: A message word other than the last is accepted on a cycle with `word_req_i` high (with `msg_start_i` for the first word) and appears unchanged on `pad_word_o` with `pad_valid_o` high one clock later; `pad_valid_o` is never high unless `word_req_i` was high one clock earlier.
- R3: With `word_req_i` low, no word is produced in the next cycle, `pad_word_o` keeps its value and the padding sequence does not advance.
- R4: For a last word with `bits_valid_i` = v < w, bits w-1 down to w-v keep the message, bit w-1-v is set to one and every lower bit is zero.
- R5: For a last word with `bits_valid_i` = w the word passes unchanged and the next padded word is a one in bit w-1 with all other bits zero.
- R6: After the word holding the one bit, zero words follow up to and including word slot 13 of the block (slots counted 0 to 15 from the block's first word).
- R7: Slots 14 and 15 of the final block carry the message length l = w*(n-1)+v as a 2w-bit number, high word in slot 14, low word in slot 15.
- R8: When the one bit falls in slot 14 or 15, the padder completes that block with zeros and emits one more block of zeros ending with the length words.
- R9: `pad_done_o` is high exactly in the cycle `pad_valid_o` carries the low length word, and no further word is produced until a new message starts.
- R10: `WORD_W` is 32 or 64, `bits_valid_i` is clog2(w)+1 bits wide so that v = w can be given, and v = 0 on the last word yields a word with only the one bit in bit w-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_word_i | input | WORD_W | Message word, MSB first |
| msg_start_i | input | 1 | First word of a new message |
| msg_last_i | input | 1 | Last word of the message |
| bits_valid_i | input | clog2(WORD_W)+1 | Real message bits in the last word |
| word_req_i | input | 1 | Consumer requests one padded word |
| pad_word_o | output | WORD_W | Padded word |
| pad_valid_o | output | 1 | `pad_word_o` holds a new word |
| pad_done_o | output | 1 | Final length word of the message |

## Verification
The properties take for granted that the source supplies a message word on every requested cycle until the last one, that a new message starts only after the previous one has finished with `pad_done_o`, and that `bits_valid_i` never exceeds w. The bench keeps within this by running one message at a time, waiting for the done marker before the next start, and driving real words only on requested cycles while placing random junk on the data pins otherwise. Request patterns are continuous, random and block-shaped so that stalls hit every padding phase, and message lengths are chosen so that the one bit lands in the middle of a block, just before the length slots, inside them, and on a word boundary.

// File: rtl/sha2pad_pkg.sv
package sha2pad_pkg;
   typedef enum logic [2:0] {
      PS_IDLE,
      PS_MSG,
      PS_ONE,
      PS_ZERO,
      PS_LENHI,
      PS_LENLO
   } pad_state_e;
endpackage

// File: rtl/sha2pad_slot.sv
// Position of the word being emitted within its block.
module sha2pad_slot #(
   parameter int BLK_WORDS = 16,
   parameter int SLOT_W    = $clog2(BLK_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              step_i,
   output logic [SLOT_W-1:0] slot_q,
   output logic              pre_len_o
);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(BLK_WORDS - 1);
   localparam logic [SLOT_W-1:0] PRE_SLOT  = SLOT_W'(BLK_WORDS - 3);

   logic [SLOT_W-1:0] cur_slot;

   assign cur_slot  = clear_i ? '0 : slot_q;
   assign pre_len_o = (cur_slot == PRE_SLOT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         slot_q <= '0;
      else if (step_i)
         slot_q <= (cur_slot == LAST_SLOT) ? '0 : cur_slot + 1'b1;
   end
endmodule

// File: rtl/sha2pad_len.sv
// Running message length in bits.
module sha2pad_len #(
   parameter int WORD_W = 32,
   parameter int BV_W   = $clog2(WORD_W) + 1,
   parameter int LEN_W  = 2 * WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             add_i,
   input  logic             start_i,
   input  logic             last_i,
   input  logic [BV_W-1:0]  bv_i,
   output logic [LEN_W-1:0] len_q
);
   logic [LEN_W-1:0] base;
   logic [LEN_W-1:0] incr;

   assign base = start_i ? '0 : len_q;
   assign incr = last_i ? LEN_W'(bv_i) : LEN_W'(WORD_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         len_q <= '0;
      else if (add_i)
         len_q <= base + incr;
   end
endmodule

// File: rtl/sha2pad_tail.sv
// Masks the last message word and inserts the one bit.
module sha2pad_tail #(
   parameter int WORD_W = 32,
   parameter int BV_W   = $clog2(WORD_W) + 1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [BV_W-1:0]   bv_i,
   output logic [WORD_W-1:0] word_o,
   output logic              full_o
);
   assign full_o = (int'(bv_i) >= WORD_W);

   for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam int DEPTH = WORD_W - 1 - b;   // distance from the MSB
      always_comb begin
         if (DEPTH < int'(bv_i))
            word_o[b] = word_i[b];
         else if (DEPTH == int'(bv_i))
            word_o[b] = 1'b1;
         else
            word_o[b] = 1'b0;
      end
   end
endmodule

// File: rtl/sha2pad_stream.sv
module sha2pad_stream #(
   parameter int WORD_W    = 32,
   parameter int BLK_WORDS = 16,
   parameter int BV_W      = $clog2(WORD_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] msg_word_i,
   input  logic              msg_start_i,
   input  logic              msg_last_i,
   input  logic [BV_W-1:0]   bits_valid_i,
   input  logic              word_req_i,
   output logic [WORD_W-1:0] pad_word_o,
   output logic              pad_valid_o,
   output logic              pad_done_o
);
   import sha2pad_pkg::*;

   localparam int LEN_W  = 2 * WORD_W;
   localparam int SLOT_W = $clog2(BLK_WORDS);
   localparam logic [WORD_W-1:0] ONE_MSB = {1'b1, {(WORD_W-1){1'b0}}};

   if (WORD_W != 32 && WORD_W != 64) begin : g_bad_width
      initial $fatal(1, "sha2pad_stream: WORD_W must be 32 or 64");
   end
   if (BLK_WORDS != 16) begin : g_bad_blk
      initial $fatal(1, "sha2pad_stream: BLK_WORDS must be 16");
   end
   if (BV_W != $clog2(WORD_W) + 1) begin : g_bad_bv
      initial $fatal(1, "sha2pad_stream: BV_W must be clog2(WORD_W)+1");
   end

   pad_state_e        st_q, st_d;
   logic              accept, emit, start_acc;
   logic              pre_len;
   logic              tail_full;
   logic [SLOT_W-1:0] slot_q;
   logic [LEN_W-1:0]  len_q;
   logic [WORD_W-1:0] tail_word;
   logic [WORD_W-1:0] word_d;

   assign start_acc = word_req_i && (st_q == PS_IDLE) && msg_start_i;
   assign accept    = start_acc || (word_req_i && (st_q == PS_MSG));
   assign emit      = accept ||
                      (word_req_i && (st_q != PS_IDLE) && (st_q != PS_MSG));

   sha2pad_slot #(.BLK_WORDS(BLK_WORDS), .SLOT_W(SLOT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (start_acc),
      .step_i   (emit),
      .slot_q   (slot_q),
      .pre_len_o(pre_len)
   );

   sha2pad_len #(.WORD_W(WORD_W), .BV_W(BV_W), .LEN_W(LEN_W)) u_len (
      .clk    (clk),
      .rst_n  (rst_n),
      .add_i  (accept),
      .start_i(start_acc),
      .last_i (msg_last_i),
      .bv_i   (bits_valid_i),
      .len_q  (len_q)
   );

   sha2pad_tail #(.WORD_W(WORD_W), .BV_W(BV_W)) u_tail (
      .word_i(msg_word_i),
      .bv_i  (bits_valid_i),
      .word_o(tail_word),
      .full_o(tail_full)
   );

   always_comb begin
      st_d   = st_q;
      word_d = '0;
      unique case (st_q)
         PS_IDLE, PS_MSG: begin
            if (accept) begin
               if (!msg_last_i) begin
                  word_d = msg_word_i;
                  st_d   = PS_MSG;
               end else if (tail_full) begin
                  word_d = msg_word_i;
                  st_d   = PS_ONE;
               end else begin
                  word_d = tail_word;
                  st_d   = pre_len ? PS_LENHI : PS_ZERO;
               end
            end
         end
         PS_ONE: begin
            word_d = ONE_MSB;
            st_d   = pre_len ? PS_LENHI : PS_ZERO;
         end
         PS_ZERO: begin
            word_d = '0;
            st_d   = pre_len ? PS_LENHI : PS_ZERO;
         end
         PS_LENHI: begin
            word_d = len_q[LEN_W-1:WORD_W];
            st_d   = PS_LENLO;
         end
         PS_LENLO: begin
            word_d = len_q[WORD_W-1:0];
            st_d   = PS_IDLE;
         end
         default: st_d = PS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= PS_IDLE;
         pad_word_o  <= '0;
         pad_valid_o <= 1'b0;
         pad_done_o  <= 1'b0;
      end else begin
         pad_valid_o <= emit;
         pad_done_o  <= emit && (st_q == PS_LENLO);
         if (emit) begin
            st_q       <= st_d;
            pad_word_o <= word_d;
         end
      end
   end
endmodule

// File: rtl/sha2pad_chk.sv
module sha2pad_chk #(
   parameter int WORD_W = 32,
   parameter int SLOT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              word_req_i,
   input logic [WORD_W-1:0] pad_word_o,
   input logic              pad_valid_o,
   input logic              pad_done_o,
   input logic [SLOT_W-1:0] slot_q
);
   assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pad_valid_o |-> $past(word_req_i));

   assert_stall_no_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !word_req_i |=> !pad_valid_o);

   assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !word_req_i |=> $stable(pad_word_o));

   assert_done_on_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pad_done_o |-> pad_valid_o);

   // The low length word occupies the last slot, so the slot counter has wrapped.
   assert_done_block_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pad_done_o |-> (slot_q == '0));
endmodule

bind sha2pad_stream sha2pad_chk #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_req_i (word_req_i),
   .pad_word_o (pad_word_o),
   .pad_valid_o(pad_valid_o),
   .pad_done_o (pad_done_o),
   .slot_q     (slot_q)
);

// File: tb/tb_sha2pad_stream.sv
module tb_sha2pad_stream;
   localparam int W    = 32;
   localparam int BV_W = $clog2(W) + 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [W-1:0]   msg_word_i = '0;
   logic           msg_start_i = 1'b0;
   logic           msg_last_i = 1'b0;
   logic [BV_W-1:0] bits_valid_i = '0;
   logic           word_req_i = 1'b0;
   logic [W-1:0]   pad_word_o;
   logic           pad_valid_o;
   logic           pad_done_o;

   sha2pad_stream #(.WORD_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .msg_word_i(msg_word_i), .msg_start_i(msg_start_i),
      .msg_last_i(msg_last_i), .bits_valid_i(bits_valid_i), .word_req_i(word_req_i),
      .pad_word_o(pad_word_o), .pad_valid_o(pad_valid_o), .pad_done_o(pad_done_o)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int done_seen = 0;
   bit finished = 0;
   logic req_at_edge = 1'b0;

   logic [W-1:0] exp_w[$];
   bit           exp_d[$];
   string        exp_t[$];
   logic [W-1:0] mw[64];

   always @(posedge clk) req_at_edge <= word_req_i;

   // Reference comparison on every clock, away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (!req_at_edge) begin
            n_chk++;
            if (pad_valid_o) begin
               n_fail++;
               $display("FAIL R3 word during stall: actual valid=%0b expected 0", pad_valid_o);
            end
         end
         if (pad_valid_o) begin
            n_chk++;
            if (exp_w.size() == 0) begin
               n_fail++;
               $display("FAIL R9 unexpected word: actual %h expected none", pad_word_o);
            end else begin
               if (pad_word_o !== exp_w[0] || pad_done_o !== exp_d[0]) begin
                  n_fail++;
                  $display("FAIL %s word: actual %h done=%0b expected %h done=%0b",
                           exp_t[0], pad_word_o, pad_done_o, exp_w[0], exp_d[0]);
               end
               void'(exp_w.pop_front());
               void'(exp_d.pop_front());
               void'(exp_t.pop_front());
            end
         end else if (pad_done_o) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 done without word: actual 1 expected 0");
         end
         if (pad_done_o) done_seen++;
      end
   end

   function automatic void push(input logic [W-1:0] w, input bit d, input string t);
      exp_w.push_back(w);
      exp_d.push_back(d);
      exp_t.push_back(t);
   endfunction

   task automatic run_msg(input int n, input int bv, input int mode);
      logic [2*W-1:0] len;
      logic [W-1:0]   last_w;
      int cnt, last_blk, idx, cyc, target;
      for (int i = 0; i < n; i++) mw[i] = $urandom;
      // expected stream
      for (int i = 0; i < n - 1; i++) push(mw[i], 0, "R2");
      last_w = mw[n-1];
      if (bv == W) begin
         push(last_w, 0, "R10");
         push({1'b1, {(W-1){1'b0}}}, 0, "R5");
      end else begin
         logic [W-1:0] kept;
         kept = (bv == 0) ? '0 : ((last_w >> (W - bv)) << (W - bv));
         push(kept | (W'(1) << (W - 1 - bv)), 0, bv == 0 ? "R10" : "R4");
      end
      last_blk = (n - 1) / 16;
      cnt = exp_w.size();
      while (cnt % 16 != 14) begin
         push('0, 0, (cnt / 16 > last_blk) ? "R8" : "R6");
         cnt++;
      end
      len = (2*W)'(n - 1) * (2*W)'(W) + (2*W)'(bv);
      push(len[2*W-1:W], 0, "R7");
      push(len[W-1:0], 1, "R9");
      target = done_seen + 1;
      // drive
      idx = 0;
      cyc = 0;
      while (done_seen < target) begin
         @(negedge clk);
         case (mode)
            0: word_req_i = 1'b1;
            1: word_req_i = ($urandom % 10) < 7;
            default: word_req_i = (cyc % 20) < 16;
         endcase
         if (word_req_i && idx < n) begin
            msg_word_i   = mw[idx];
            msg_start_i  = (idx == 0);
            msg_last_i   = (idx == n - 1);
            bits_valid_i = (idx == n - 1) ? BV_W'(bv) : BV_W'($urandom % W);
            idx++;
         end else begin
            msg_word_i   = $urandom;
            msg_start_i  = 1'b0;
            msg_last_i   = 1'b0;
            bits_valid_i = BV_W'($urandom % W);
         end
         cyc++;
      end
      // idle tail: nothing more may appear (R9)
      repeat (4) begin
         @(negedge clk);
         word_req_i = 1'b1;
      end
      @(negedge clk);
      n_chk++;
      if (exp_w.size() != 0) begin
         n_fail++;
         $display("FAIL R9 words missing: actual %0d left expected 0", exp_w.size());
         exp_w.delete(); exp_d.delete(); exp_t.delete();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      word_req_i = 1'b1;
      repeat (3) @(negedge clk);
      n_chk++;   // R1 reset state
      if (pad_valid_o !== 1'b0 || pad_done_o !== 1'b0 || pad_word_o !== '0) begin
         n_fail++;
         $display("FAIL R1 reset: actual v=%0b d=%0b w=%h expected 0 0 0",
                  pad_valid_o, pad_done_o, pad_word_o);
      end
      rst_n = 1'b1;
      word_req_i = 1'b0;
      @(negedge clk);
      n_chk++;   // R1 right after release, no request yet
      if (pad_valid_o !== 1'b0 || pad_done_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 after reset: actual v=%0b d=%0b expected 0 0", pad_valid_o, pad_done_o);
      end
      run_msg(1, 0, 0);     // R10 empty last word
      run_msg(1, 5, 0);     // R4 partial single word
      run_msg(3, W, 0);     // R5 word-aligned end
      run_msg(14, 31, 1);   // one bit in slot 13, length follows directly
      run_msg(15, 7, 0);    // R8 one bit in slot 14
      run_msg(16, 3, 2);    // R8 one bit in slot 15
      run_msg(14, W, 1);    // R8 full last word, one-word in slot 14
      run_msg(16, W, 0);    // R5 one-word opens next block
      run_msg(20, 17, 2);   // R6 zero fill in second block
      run_msg(40, 1, 1);    // R7 multi-block length
      run_msg(2, 31, 1);    // R4 one bit in bit 0
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule